// File: doc/BRIEF.md
# Buffered Compare/Capture Timer Channel

This block is one 16-bit timer channel. A free-running up-counter advances by one on every clock while the run bit is set, and four general registers watch it. Each general register is separately configured as a compare register, which flags a match when the counter reaches its value, or as a capture register, which copies the counter when the capture input rises. The first two registers also drive one output pin each. On a compare match, each pin can be cleared, set or toggled.

Registers C and D can be made shadow buffers of A and B. In compare mode a buffered register reloads its partner from the shadow on every match, so that software can queue the next match point without a race. In capture mode each capture pushes the previous value down into the shadow, so the two most recent capture times are kept. The host reaches everything through a single-cycle synchronous register bus. The counter and the general registers accept only full 16-bit accesses.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter, all general registers and all event flags read 0x0000, the run bit reads 0 and both output pins are low.
- R2: While the run bit (address 0x0, bit 0) is 1 the counter increases by one on every clock and wraps from 0xFFFF to 0x0000. While it is 0 the counter holds its value.
- R3: The counter (address 0x4) and the general registers A..D (addresses 0x8..0xB) ignore writes made with bus_wide low, and return 0x0000 on reads made with bus_wide low.
- R4: Bits 15..1 of the run register always read as 0, whatever value was written to them.
- R5: The mode register is at address 0x1. In it, bit i (i = 0..3) set to 0 makes register i a compare register. In compare mode, when the counter is running and equals register i, flag bit i (flag register, address 0x3) is set. On that same edge pin 0 (for A) or pin 1 (for B) applies its action. The pin register is at address 0x2: bits 1:0 hold the action for pin 0 and bits 5:4 the action for pin 1, with 0 = none, 1 = drive low, 2 = drive high and 3 = toggle.
- R6: While the run bit is 0 the output pins keep their level, unless the pin register is written.
- R7: A write to the pin register while the run bit is 0 drives pin 0 to bit 2 and pin 1 to bit 6 of the written value on the next edge. The same write while running leaves the pins unchanged.
- R8: When mode bit 4 is set, C buffers A, and when mode bit 5 is set, D buffers B. A compare match of A or B then copies the buffer into A or B on the match edge. A buffer register raises no flags of its own.
- R9: In capture mode (mode bit i = 1), a rising edge on cap_in loads register i with the counter value and sets flag bit 4+i.
- R10: In capture mode with buffering on, a capture first moves the old value of A or B into its buffer C or D, and then loads A or B with the counter.
- R11: Flag bits are cleared by writing 1 to them. Writing 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = full 16-bit access, 0 = byte access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| cap_in | input | 1 | Capture trigger, synchronous to clk |
| cmp_out | output | 2 | Compare output pins (bit 0 from A, bit 1 from B) |

## Verification
The properties assume that cap_in is already synchronous to clk and that each bus access lasts exactly one cycle. They also assume that a bus write to the counter is the only thing, apart from counting, that moves the counter, so the checks for counting and holding exclude cycles with such a write. To make the expected values exact, the stimulus takes every capture with the counter halted. Compare tests start from a known loaded count and stop the counter before it can reach a second match or wrap onto a register value again.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 4;
    localparam int NUM_GR = 4;
    localparam int NUM_PIN = 2;
    localparam int HALF_GR = NUM_GR / 2;
    localparam int FLAG_W = 2 * NUM_GR;

    localparam logic [ADDR_W-1:0] ADR_RUN  = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_MODE = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_PIN  = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_GR0  = 4'h8;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_FLIP = 2'd3
    } pin_act_e;

    typedef struct packed {
        logic [HALF_GR-1:0] buf_en;
        logic [NUM_GR-1:0]  cap_en;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int PIN_FIELD = 4;
    localparam int PIN_CFG_W = PIN_FIELD * NUM_PIN;

    function automatic logic pin_apply(logic cur, pin_act_e act);
        case (act)
            ACT_LOW:  pin_apply = 1'b0;
            ACT_HIGH: pin_apply = 1'b1;
            ACT_FLIP: pin_apply = ~cur;
            default:  pin_apply = cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (run) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_gr_bank.sv
module tmr_gr_bank
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [W-1:0]      cnt,
    input  mode_t             mode,
    input  logic              cap_rise,
    input  logic [NUM_GR-1:0] wr_en,
    input  logic [W-1:0]      wr_val,
    output logic [W-1:0]      gr [NUM_GR],
    output logic [NUM_GR-1:0] cmp_hit,
    output logic [NUM_GR-1:0] cap_hit
);
    logic [NUM_GR-1:0] is_buf;

    genvar i;
    generate
        for (i = 0; i < NUM_GR; i++) begin : g_evt
            if (i < HALF_GR) begin : g_pri
                assign is_buf[i] = 1'b0;
            end else begin : g_sec
                assign is_buf[i] = mode.buf_en[i-HALF_GR];
            end
            assign cmp_hit[i] = run && !mode.cap_en[i] && !is_buf[i] && (cnt == gr[i]);
            assign cap_hit[i] = cap_rise && mode.cap_en[i] && !is_buf[i];
        end

        for (i = 0; i < HALF_GR; i++) begin : g_pair
            localparam int S = i + HALF_GR;
            always_ff @(posedge clk) begin
                if (rst)                                   gr[i] <= '0;
                else if (wr_en[i])                         gr[i] <= wr_val;
                else if (cap_hit[i])                       gr[i] <= cnt;
                else if (cmp_hit[i] && mode.buf_en[i])     gr[i] <= gr[S];
            end
            always_ff @(posedge clk) begin
                if (rst)                                   gr[S] <= '0;
                else if (wr_en[S])                         gr[S] <= wr_val;
                else if (mode.buf_en[i] && cap_hit[i])     gr[S] <= gr[i];
                else if (cap_hit[S])                       gr[S] <= cnt;
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl
    import tmr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          run,
    input  logic [NUM_PIN-1:0][1:0]       act,
    input  logic                          cfg_wr,
    input  logic [NUM_PIN-1:0]            init_lvl,
    input  logic [NUM_PIN-1:0]            hit,
    output logic [NUM_PIN-1:0]            pin
);
    genvar p;
    generate
        for (p = 0; p < NUM_PIN; p++) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst)                 pin[p] <= 1'b0;
                else if (cfg_wr && !run) pin[p] <= init_lvl[p];
                else if (hit[p])         pin[p] <= pin_apply(pin[p], pin_act_e'(act[p]));
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic               bus_wide,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic               cap_in,
    output logic [NUM_PIN-1:0] cmp_out
);
    logic                   run_q;
    mode_t                  mode_q;
    logic [PIN_CFG_W-1:0]   pin_cfg_q;
    logic [FLAG_W-1:0]      flag_q;
    logic                   cap_q;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       gr [NUM_GR];
    logic [NUM_GR-1:0]      cmp_hit, cap_hit, gr_wr;

    logic wr_any, wide_wr, cap_rise, pin_wr;
    logic [NUM_PIN-1:0][1:0] pin_act;
    logic [NUM_PIN-1:0]      pin_init_new;

    assign wr_any   = bus_sel && bus_we;
    assign wide_wr  = wr_any && bus_wide;
    assign cap_rise = cap_in && !cap_q;
    assign pin_wr   = wr_any && (bus_addr == ADR_PIN);

    genvar i;
    generate
        for (i = 0; i < NUM_GR; i++) begin : g_grwr
            assign gr_wr[i] = wide_wr && (bus_addr == ADDR_W'(ADR_GR0 + i));
        end
        for (i = 0; i < NUM_PIN; i++) begin : g_pcfg
            assign pin_act[i]      = pin_cfg_q[PIN_FIELD*i +: 2];
            assign pin_init_new[i] = bus_wdata[PIN_FIELD*i + 2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            mode_q    <= '0;
            pin_cfg_q <= '0;
            flag_q    <= '0;
            cap_q     <= 1'b0;
        end else begin
            cap_q <= cap_in;
            if (wr_any && bus_addr == ADR_RUN)  run_q  <= bus_wdata[0];
            if (wr_any && bus_addr == ADR_MODE) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
            if (pin_wr)                         pin_cfg_q <= bus_wdata[PIN_CFG_W-1:0];
            flag_q <= (flag_q & ~((wr_any && bus_addr == ADR_FLAG) ? bus_wdata[FLAG_W-1:0] : '0))
                      | {cap_hit, cmp_hit};
        end
    end

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .ld     (wide_wr && bus_addr == ADR_CNT),
        .ld_val (bus_wdata),
        .cnt    (cnt)
    );

    tmr_gr_bank #(.W(CNT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .cnt      (cnt),
        .mode     (mode_q),
        .cap_rise (cap_rise),
        .wr_en    (gr_wr),
        .wr_val   (bus_wdata),
        .gr       (gr),
        .cmp_hit  (cmp_hit),
        .cap_hit  (cap_hit)
    );

    tmr_pin_ctl u_pin (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .act      (pin_act),
        .cfg_wr   (pin_wr),
        .init_lvl (pin_init_new),
        .hit      (cmp_hit[NUM_PIN-1:0]),
        .pin      (cmp_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_RUN:  bus_rdata[0] = run_q;
            ADR_MODE: bus_rdata[MODE_W-1:0] = mode_q;
            ADR_PIN:  bus_rdata[PIN_CFG_W-1:0] = pin_cfg_q;
            ADR_FLAG: bus_rdata[FLAG_W-1:0] = flag_q;
            ADR_CNT:  if (bus_wide) bus_rdata = cnt;
            default: begin
                if (bus_wide && bus_addr[3] && !bus_addr[2])
                    bus_rdata = gr[bus_addr[1:0]];
            end
        endcase
    end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_we,
    input logic               bus_wide,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [CNT_W-1:0]   bus_wdata,
    input logic [CNT_W-1:0]   bus_rdata,
    input logic [NUM_PIN-1:0] cmp_out,
    input logic               run_q,
    input logic [CNT_W-1:0]   cnt
);
    logic cnt_wr, pin_wr, wide_reg;
    assign cnt_wr   = bus_sel && bus_we && bus_wide && bus_addr == ADR_CNT;
    assign pin_wr   = bus_sel && bus_we && bus_addr == ADR_PIN;
    assign wide_reg = bus_addr == ADR_CNT || (bus_addr[3] && !bus_addr[2]);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        run_q && !cnt_wr |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q && !cnt_wr |=> $stable(cnt));

    // R6
    pin_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q && !pin_wr |=> $stable(cmp_out));

    // R7
    pin_init_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q && pin_wr |=> cmp_out == {$past(bus_wdata[PIN_FIELD+2]), $past(bus_wdata[2])});

    // R3
    narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_sel && !bus_we && !bus_wide && wide_reg |-> bus_rdata == '0);

    // R4
    run_upper_chk: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_addr == ADR_RUN |-> bus_rdata[CNT_W-1:1] == '0);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wide  (bus_wide),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_out   (cmp_out),
    .run_q     (run_q),
    .cnt       (cnt)
);

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0, bus_wide = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cap_in = 1'b0;
    logic [1:0]  cmp_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        bit          is_pin;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    tmr_channel dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_in(cap_in), .cmp_out(cmp_out)
    );

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb_q.pop_front();
            act = it.is_pin ? {14'b0, cmp_out} : bus_rdata;
            tests++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            bus_sel = 1'b0; bus_we = 1'b0; bus_wide = 1'b1;
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d, logic wide = 1'b1);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(logic [3:0] a, logic [15:0] e, string tag, logic wide = 1'b1);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_wide = wide; bus_addr = a;
        it.is_pin = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic pchk(logic [1:0] e, string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        it.is_pin = 1'b1; it.exp = {14'b0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic pulse();
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; cap_in = 1'b1;
        @(posedge clk); #1;
        cap_in = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(ADR_CNT, 16'h0000, "R1 count");
        rd(ADR_GR0, 16'h0000, "R1 reg A");
        rd(ADR_GR0 + 4'd3, 16'h0000, "R1 reg D");
        rd(ADR_FLAG, 16'h0000, "R1 flags");
        rd(ADR_RUN, 16'h0000, "R1 run");
        pchk(2'b00, "R1 pins");

        // R2 counting with wrap, then halt
        wr(ADR_CNT, 16'hFFFD);
        wr(ADR_RUN, 16'h0001);
        idle(3);
        wr(ADR_RUN, 16'h0000);
        rd(ADR_CNT, 16'h0001, "R2 wrap");
        idle(2);
        rd(ADR_CNT, 16'h0001, "R2 hold");

        // R5 compare with pin actions
        wr(ADR_MODE, 16'h0000);
        wr(ADR_PIN, 16'h0023);
        wr(ADR_GR0, 16'd5);
        wr(ADR_GR0 + 4'd1, 16'd7);
        wr(ADR_GR0 + 4'd2, 16'h0100);
        wr(ADR_GR0 + 4'd3, 16'h0100);
        wr(ADR_CNT, 16'h0000);
        wr(ADR_FLAG, 16'h00FF);
        wr(ADR_RUN, 16'h0001);
        idle(10);
        wr(ADR_RUN, 16'h0000);
        pchk(2'b11, "R5 pins after match");
        rd(ADR_FLAG, 16'h0003, "R5 flags");
        rd(ADR_CNT, 16'd11, "R2 count after run");

        // R6 frozen while halted
        idle(3);
        pchk(2'b11, "R6 pins frozen");

        // R7 forced init while halted, ignored while running
        wr(ADR_PIN, 16'h0063);
        pchk(2'b10, "R7 init forced");
        wr(ADR_RUN, 16'h0001);
        wr(ADR_PIN, 16'h0027);
        pchk(2'b10, "R7 running write");
        wr(ADR_RUN, 16'h0000);

        // R11 write-one-to-clear
        wr(ADR_FLAG, 16'h0001);
        rd(ADR_FLAG, 16'h0002, "R11 clear bit0");
        wr(ADR_FLAG, 16'h0000);
        rd(ADR_FLAG, 16'h0002, "R11 zero keeps");
        wr(ADR_FLAG, 16'h0002);
        rd(ADR_FLAG, 16'h0000, "R11 clear bit1");

        // R8 buffered compare
        wr(ADR_MODE, 16'h0010);
        wr(ADR_PIN, 16'h0003);
        wr(ADR_GR0, 16'd3);
        wr(ADR_GR0 + 4'd2, 16'd9);
        wr(ADR_CNT, 16'h0000);
        wr(ADR_RUN, 16'h0001);
        idle(5);
        wr(ADR_RUN, 16'h0000);
        rd(ADR_GR0, 16'd9, "R8 A reloaded");
        rd(ADR_GR0 + 4'd2, 16'd9, "R8 C kept");
        pchk(2'b01, "R8 pin toggled");
        rd(ADR_FLAG, 16'h0001, "R8 flags");

        // R9 capture into B
        wr(ADR_MODE, 16'h0002);
        wr(ADR_CNT, 16'h1234);
        wr(ADR_FLAG, 16'h00FF);
        pulse();
        rd(ADR_GR0 + 4'd1, 16'h1234, "R9 B captured");
        rd(ADR_FLAG, 16'h0020, "R9 capture flag");

        // R10 buffered capture into A with C
        wr(ADR_MODE, 16'h0011);
        wr(ADR_GR0, 16'h0AAA);
        wr(ADR_CNT, 16'h0055);
        pulse();
        rd(ADR_GR0, 16'h0055, "R10 A first");
        rd(ADR_GR0 + 4'd2, 16'h0AAA, "R10 C first");
        wr(ADR_CNT, 16'h0066);
        pulse();
        rd(ADR_GR0, 16'h0066, "R10 A second");
        rd(ADR_GR0 + 4'd2, 16'h0055, "R10 C second");

        // R3 byte accesses
        wr(ADR_GR0, 16'hBEEF, 1'b0);
        rd(ADR_GR0, 16'h0066, "R3 byte write ignored");
        rd(ADR_GR0, 16'h0000, "R3 byte read zero", 1'b0);
        wr(ADR_CNT, 16'h0007, 1'b0);
        rd(ADR_CNT, 16'h0066, "R3 count byte write");
        rd(ADR_CNT, 16'h0000, "R3 count byte read", 1'b0);

        // R4 upper run bits
        wr(ADR_RUN, 16'hFFFE);
        rd(ADR_RUN, 16'h0000, "R4 upper ignored");
        wr(ADR_RUN, 16'h00FF);
        rd(ADR_RUN, 16'h0001, "R4 only bit0");
        wr(ADR_RUN, 16'h0000);
        idle(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule